// File: doc/BRIEF.md
# Burst Beat Address Stepper

This block takes one burst request of the kind carried on an AXI4 read or write address channel, and expands it into one address per data beat. A request carries a start address, a length field, a size code and a burst kind. It is taken in through a valid/ready handshake. The block then presents the beat addresses one at a time on a downstream valid/ready port and marks the final beat with a last flag.

A data mover or memory model sits behind the block and consumes one address per transferred beat. The block supports the three address behaviours: held, linear and wrapping. Every power-of-two beat width from 1 to 128 bytes is handled, including the wrap-window arithmetic for each width. A second request waits until the final beat of the current burst has been handed off.

Top module: `burst_addr_stepper`

## Requirements
- R1: After reset, `beat_valid` is low and `req_ready` is high.
- R2: A request is taken only on a rising edge where `req_valid` and `req_ready` are both high. From the next cycle, `beat_valid` is high and `beat_addr` equals the request's start address unchanged.
- R3: A burst produces exactly `req_len`+1 beats, so length 0 gives one beat and length 255 gives 256 beats. `beat_last` is high on the final beat only. After the final handoff, `beat_valid` is low in the next cycle.
- R4: Size code `s` (0 to 7) means 2^s bytes per beat.
- R5: Kind code 0 (held) presents the start address on every beat.
- R6: Kind code 1 (linear) aligns the current address down to the beat width and then adds the beat width. So after an unaligned start, the second and later beats are aligned.
- R7: Kind code 2 (wrapping) uses a window of beats × beat-width bytes, placed at the start address aligned down to that window size. Addresses advance as in R6. When the next address would reach the top of the window, it returns to the window base instead.
- R8: Kind code 2 with a beat count other than 2, 4, 8 or 16 is stepped as linear (R6). Kind code 3 is also stepped as linear.
- R9: While `beat_valid` is high and `beat_ready` is low, `beat_addr` and `beat_last` hold their values. A beat transfers only on an edge where both `beat_valid` and `beat_ready` are high.
- R10: `req_ready` is low from the cycle after acceptance until the final beat has been handed off, and is high again in the next cycle. A `req_valid` raised while `req_ready` is low has no effect on the burst in flight and starts no new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Beat count minus one |
| req_size | input | 3 | Beat width code, 2^code bytes |
| req_kind | input | 2 | 0 held, 1 linear, 2 wrapping, 3 treated as linear |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Consumer takes the beat address |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |

## Verification
A corrupted beat counter shows up as a `beat_last` on the wrong beat, or as a burst that ends early or runs long. The error is visible at the latest at the handoff where the final beat was expected. A wrong step mask or window base shows up at the very next handoff after the first beat, as a misaligned or out-of-window `beat_addr`. A wrong busy state shows up one cycle after acceptance or after the final handoff, as a wrong `req_ready`, or as an address that moves while the consumer stalls.

// File: rtl/bstep_pkg.sv
package bstep_pkg;

    // Burst kind codes as carried on the request port.
    typedef enum logic [1:0] {
        BK_HELD   = 2'd0,
        BK_LINEAR = 2'd1,
        BK_WRAP   = 2'd2,
        BK_SPARE  = 2'd3
    } burst_kind_e;

    // Internal stepping behaviour after legality resolution.
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_LINEAR = 2'd1,
        STEP_WINDOW = 2'd2
    } step_mode_e;

    // Width of the size code: eight power-of-two beat widths.
    localparam int SIZE_W = 3;

    // Map the request kind to a stepping behaviour.
    // A wrapping request with an unsupported beat count falls back to linear.
    function automatic step_mode_e resolve_mode(input burst_kind_e kind, input logic wrap_ok);
        step_mode_e m;
        case (kind)
            BK_HELD:   m = STEP_HOLD;
            BK_WRAP:   m = wrap_ok ? STEP_WINDOW : STEP_LINEAR;
            default:   m = STEP_LINEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bstep_decode.sv
module bstep_decode
    import bstep_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        kind,
    output step_mode_e        mode,
    output logic [ADDR_W-1:0] step_mask,
    output logic [ADDR_W-1:0] win_mask,
    output logic [ADDR_W-1:0] win_base
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              wrap_ok;
    logic [ADDR_W-1:0] beats;

    // Beat counts allowed for a wrapping burst: 2, 4, 8, 16.
    always_comb begin
        wrap_ok = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                  (len == LEN_W'(7)) || (len == LEN_W'(15));
        mode    = resolve_mode(burst_kind_e'(kind), wrap_ok);
    end

    always_comb begin
        beats     = ADDR_W'(len) + ONE;
        step_mask = (ONE << size) - ONE;
        win_mask  = (mode == STEP_WINDOW) ? ((beats << size) - ONE) : '0;
        win_base  = addr & ~win_mask;
    end

endmodule

// File: rtl/bstep_next.sv
module bstep_next
    import bstep_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              chk_en,
    input  logic [ADDR_W-1:0] cur,
    input  step_mode_e        mode,
    input  logic [ADDR_W-1:0] step_mask,
    input  logic [ADDR_W-1:0] win_mask,
    input  logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] advanced;
    logic              left_window;

    always_comb begin
        aligned     = cur & ~step_mask;
        advanced    = aligned + step_mask + ADDR_W'(1);
        left_window = (advanced & ~win_mask) != win_base;
        case (mode)
            STEP_HOLD:   nxt = cur;
            STEP_WINDOW: nxt = left_window ? win_base : advanced;
            default:     nxt = advanced;
        endcase
    end

    // R7: a wrapping burst never steps outside its window.
    always_comb begin
        if (chk_en && mode == STEP_WINDOW) begin
            p_in_window_r7: assert ((nxt & ~win_mask) == win_base)
                else $error("wrap step left its window");
        end
    end

endmodule

// File: rtl/bstep_beat_cnt.sv
module bstep_beat_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             advance,
    output logic             at_last
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_len;
        end else if (advance && remain != '0) begin
            remain <= remain - LEN_W'(1);
        end
    end

    assign at_last = (remain == '0);

    // R3: a fresh load of a multi-beat burst does not flag last at once.
    p_load_not_last_r3: assert property (@(posedge clk) disable iff (rst)
        (load && load_len != '0) |=> !at_last);

endmodule

// File: rtl/burst_addr_stepper.sv
module burst_addr_stepper
    import bstep_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [2:0]        req_size,
    input  logic [1:0]        req_kind,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_last
);
    typedef struct packed {
        logic              busy;
        step_mode_e        mode;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] step_mask;
        logic [ADDR_W-1:0] win_mask;
        logic [ADDR_W-1:0] win_base;
    } walk_state_t;

    walk_state_t       st;
    step_mode_e        dec_mode;
    logic [ADDR_W-1:0] dec_step_mask;
    logic [ADDR_W-1:0] dec_win_mask;
    logic [ADDR_W-1:0] dec_win_base;
    logic [ADDR_W-1:0] nxt_addr;
    logic              accept;
    logic              handoff;
    logic              cnt_last;

    assign req_ready  = !st.busy;
    assign accept     = req_valid && req_ready;
    assign beat_valid = st.busy;
    assign beat_addr  = st.cur;
    assign beat_last  = st.busy && cnt_last;
    assign handoff    = beat_valid && beat_ready;

    bstep_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_decode (
        .addr      (req_addr),
        .len       (req_len),
        .size      (req_size),
        .kind      (req_kind),
        .mode      (dec_mode),
        .step_mask (dec_step_mask),
        .win_mask  (dec_win_mask),
        .win_base  (dec_win_base)
    );

    bstep_next #(.ADDR_W(ADDR_W)) u_next (
        .chk_en    (st.busy),
        .cur       (st.cur),
        .mode      (st.mode),
        .step_mask (st.step_mask),
        .win_mask  (st.win_mask),
        .win_base  (st.win_base),
        .nxt       (nxt_addr)
    );

    bstep_beat_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_len (req_len),
        .advance  (handoff),
        .at_last  (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{busy: 1'b0, mode: STEP_HOLD, cur: '0,
                    step_mask: '0, win_mask: '0, win_base: '0};
        end else if (accept) begin
            st <= '{busy: 1'b1, mode: dec_mode, cur: req_addr,
                    step_mask: dec_step_mask, win_mask: dec_win_mask,
                    win_base: dec_win_base};
        end else if (handoff) begin
            if (cnt_last) begin
                st.busy <= 1'b0;
            end else begin
                st.cur <= nxt_addr;
            end
        end
    end

    // R2: an accepted request shows its start address on the next cycle.
    p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (beat_valid && beat_addr == $past(req_addr)));

    // R3 / R10: the final handoff ends the burst and reopens the request port.
    p_last_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (handoff && beat_last) |=> (!beat_valid && req_ready));

    // R5: a held burst repeats its address.
    p_held_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (handoff && !beat_last && st.mode == STEP_HOLD) |=> $stable(beat_addr));

    // R6: after a step, a linear or wrapping address is aligned to the beat width.
    p_step_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        (handoff && !beat_last && st.mode != STEP_HOLD) |=> ((beat_addr & st.step_mask) == '0));

    // R9: a stalled beat keeps its address and last flag.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_last)));

endmodule

// File: tb/burst_addr_stepper_tb.sv
module burst_addr_stepper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [7:0]  req_len;
    logic [2:0]  req_size;
    logic [1:0]  req_kind;
    logic        beat_valid;
    logic        beat_ready;
    logic [31:0] beat_addr;
    logic        beat_last;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_stepper #(.ADDR_W(32), .LEN_W(8)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_kind(req_kind),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_last(beat_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected next address from the requirements (R4..R8).
    function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [31:0] start,
                                               input logic [7:0] len, input logic [2:0] size,
                                               input logic [1:0] kind);
        logic [31:0] bytes, beats, step, span, base;
        bytes = 32'd1 << size;
        beats = {24'd0, len} + 32'd1;
        if (kind == 2'd0) return cur;
        step = cur - (cur % bytes) + bytes;
        if (kind == 2'd2 && (beats == 2 || beats == 4 || beats == 8 || beats == 16)) begin
            span = beats * bytes;
            base = start - (start % span);
            if (step >= base + span) step = base;
        end
        return step;
    endfunction

    // One burst: optional stall every stall_mod cycles, optional request poke while busy.
    task automatic run_burst(input string req, input logic [31:0] a, input logic [7:0] l,
                             input logic [2:0] s, input logic [1:0] k,
                             input int stall_mod, input bit poke);
        logic [31:0] exp, held;
        int beats = 0;
        int cyc = 0;
        bit was_held = 1'b0;
        @(negedge clk);
        req_addr = a; req_len = l; req_size = s; req_kind = k; req_valid = 1'b1;
        check(req_ready == 1'b1, "R2", "req_ready before accept", {31'd0, req_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(beat_valid && !req_ready, "R10", "busy after accept",
              {30'd0, beat_valid, req_ready}, 32'd2);
        exp = a;
        while (beats <= int'(l) && cyc < 5000) begin
            if (was_held) begin
                check(beat_addr == held, "R9", "address held during stall", beat_addr, held);
            end
            req_valid  = (poke && cyc == 1);
            if (poke && cyc == 1) begin
                req_addr = 32'hDEAD_0000; req_kind = 2'd1;
            end
            beat_ready = (stall_mod == 0) || (cyc % stall_mod != 0);
            was_held   = !beat_ready && beat_valid;
            held       = beat_addr;
            if (beat_valid && beat_ready) begin
                check(beat_addr == exp, req, $sformatf("beat %0d address", beats), beat_addr, exp);
                check(beat_last == (beats == int'(l)), "R3", $sformatf("beat %0d last", beats),
                      {31'd0, beat_last}, {31'd0, beats == int'(l)});
                exp = model_next(exp, a, l, s, k);
                beats++;
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        req_valid  = 1'b0;
        beat_ready = 1'b0;
        check(beats == int'(l) + 1, "R3", "beat count", beats, int'(l) + 1);
        check(!beat_valid && req_ready, "R10", "idle after final beat",
              {30'd0, beat_valid, req_ready}, 32'd1);
        @(negedge clk);
        check(!beat_valid, "R10", "no extra burst", {31'd0, beat_valid}, 32'd0);
    endtask

    task automatic test_reset();
        rst = 1'b1; req_valid = 1'b0; beat_ready = 1'b0;
        req_addr = '0; req_len = '0; req_size = '0; req_kind = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!beat_valid, "R1", "beat_valid after reset", {31'd0, beat_valid}, 32'd0);
        check(req_ready, "R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic test_no_accept_without_valid();
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(!beat_valid, "R2", "no burst without req_valid", {31'd0, beat_valid}, 32'd0);
    endtask

    initial begin
        test_reset();
        test_no_accept_without_valid();
        run_burst("R5", 32'h0000_1234, 8'd3, 3'd2, 2'd0, 0, 1'b0);
        run_burst("R6", 32'h0000_1003, 8'd3, 3'd2, 2'd1, 0, 1'b0);
        run_burst("R7", 32'h0000_1008, 8'd3, 3'd2, 2'd2, 0, 1'b0);
        run_burst("R7", 32'h2000_0700, 8'd15, 3'd7, 2'd2, 0, 1'b0);
        run_burst("R7", 32'h0000_0041, 8'd1, 3'd0, 2'd2, 3, 1'b0);
        run_burst("R8", 32'h0000_3008, 8'd2, 3'd2, 2'd2, 0, 1'b0);
        run_burst("R8", 32'h0000_5006, 8'd2, 3'd1, 2'd3, 0, 1'b0);
        run_burst("R4", 32'h0000_8000, 8'd3, 3'd6, 2'd1, 0, 1'b0);
        run_burst("R3", 32'h0000_9000, 8'd0, 3'd3, 2'd1, 0, 1'b0);
        run_burst("R9", 32'h0001_0000, 8'd255, 3'd0, 2'd1, 4, 1'b0);
        run_burst("R10", 32'h0000_A010, 8'd3, 3'd2, 2'd1, 2, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule